// File: doc/BRIEF.md
# Hybrid Rule 90/150 Cellular Automaton Pattern Generator

This block is a one-dimensional cellular-automaton register that produces pseudo-random test patterns. Each cell computes its next value from three bits: the cell to its left, itself and the cell to its right. A per-cell parameter bit selects the cell's rule. Rule 90 takes the XOR of the two neighbours. Rule 150 also folds in the cell's own value. Unlike a shift-based generator, the pattern does not visibly slide from one bit to the next.

The ends of the register are handled by a boundary parameter. The default is the null boundary, where the absent neighbour beyond each end reads as 0. An alternative cyclic boundary joins the two ends, so that each end cell sees the cell at the other end. The null boundary is the one known to give maximal-length configurations. In the default six-cell arrangement, cell 0 uses rule 150 and the other five cells use rule 90, and the register runs through every non-zero state before it repeats.

A seed is loaded to start a run. The all-zero state never leaves itself, so a zero seed is not taken as given. Instead, cell 0 is forced to 1 and a warning flag is raised for one cycle.

Top module: `hybrid_ca_gen`

## Requirements
- R1: While rst_ni is low, and after it rises, state_o equals RESET_STATE (default 000001) and seed_zero_o is 0.
- R2: When load_i is 1 and seed_i is non-zero, state_o equals seed_i after the next clock edge, whatever enable_i is.
- R3: When load_i is 1 and seed_i is all zeros, state_o becomes 000...001 (cell 0 set, every other cell clear) after the next edge. seed_zero_o is 1 for exactly that cycle and 0 in every other cycle.
- R4: With load_i at 0 and enable_i at 0, state_o keeps its value.
- R5: With load_i at 0 and enable_i at 1, a cell whose RULE150_MASK bit is 0 (rule 90, truth table 01011010 read from neighbourhood 7 down to 0) takes left XOR right. Cell i has cell i-1 as its left neighbour and cell i+1 as its right neighbour.
- R6: In the same conditions, a cell whose RULE150_MASK bit is 1 (rule 150, truth table 10010110) takes left XOR self XOR right.
- R7: With CYCLIC at 0, the left neighbour of cell 0 and the right neighbour of cell WIDTH-1 read as 0.
- R8: With CYCLIC at 1, the left neighbour of cell 0 is cell WIDTH-1, and the right neighbour of cell WIDTH-1 is cell 0.
- R9: With WIDTH 6, mask 000001 and the null boundary, a run started from a non-zero seed returns to that seed after exactly 63 steps and repeats no state before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load seed_i into the register; takes priority over enable_i |
| seed_i | input | WIDTH | Seed value |
| enable_i | input | 1 | Advance the automaton by one step |
| state_o | output | WIDTH | Current register state |
| seed_zero_o | output | 1 | Pulses when an all-zero seed was replaced |

## Verification
The assertions take for granted that load_i, enable_i and seed_i are known and stable around each rising edge. They do not constrain seed_i, because the zero-seed substitution is itself checked.

The stimulus changes inputs only just after an edge. It draws seeds at random and mixes load and enable at random. Directed all-zero seeds and a full-period run from a known seed are added, and a cyclic-boundary instance is driven in parallel with the null-boundary one.

// File: rtl/ca_pkg.sv
package ca_pkg;
  // Elementary rule truth tables, indexed by {left, self, right}
  localparam logic [7:0] RULE_90_TBL  = 8'b0101_1010;
  localparam logic [7:0] RULE_150_TBL = 8'b1001_0110;

  typedef enum logic {
    RULE_90  = 1'b0,
    RULE_150 = 1'b1
  } ca_rule_e;

  function automatic logic [7:0] rule_table(ca_rule_e r);
    return (r == RULE_150) ? RULE_150_TBL : RULE_90_TBL;
  endfunction
endpackage

// File: rtl/ca_boundary.sv
module ca_boundary #(
  parameter int unsigned WIDTH  = 6,
  parameter bit          CYCLIC = 1'b0
) (
  input  logic [WIDTH-1:0] state_i,
  output logic [WIDTH+1:0] ext_o
);
  // ext_o[0] is the left pad, ext_o[WIDTH+1] is the right pad
  if (CYCLIC) begin : g_cyclic
    assign ext_o = {state_i[0], state_i, state_i[WIDTH-1]};
  end else begin : g_null
    assign ext_o = {1'b0, state_i, 1'b0};
  end
endmodule

// File: rtl/ca_cell.sv
module ca_cell
  import ca_pkg::*;
#(
  parameter ca_rule_e RULE = RULE_90
) (
  input  logic left_i,
  input  logic self_i,
  input  logic right_i,
  output logic next_o
);
  localparam logic [7:0] TBL = rule_table(RULE);

  assign next_o = TBL[{left_i, self_i, right_i}];
endmodule

// File: rtl/ca_seed_guard.sv
module ca_seed_guard #(
  parameter int unsigned WIDTH = 6
) (
  input  logic [WIDTH-1:0] seed_i,
  output logic [WIDTH-1:0] seed_o,
  output logic             zero_o
);
  localparam logic [WIDTH-1:0] FORCED = WIDTH'(1);

  assign zero_o = ~|seed_i;
  assign seed_o = zero_o ? FORCED : seed_i;
endmodule

// File: rtl/hybrid_ca_gen.sv
module hybrid_ca_gen
  import ca_pkg::*;
#(
  parameter int unsigned      WIDTH        = 6,
  parameter logic [WIDTH-1:0] RULE150_MASK = WIDTH'(1),
  parameter bit               CYCLIC       = 1'b0,
  parameter logic [WIDTH-1:0] RESET_STATE  = WIDTH'(1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             enable_i,
  output logic [WIDTH-1:0] state_o,
  output logic             seed_zero_o
);
  localparam logic [WIDTH-1:0] ONE_HOT0 = WIDTH'(1);

  logic [WIDTH-1:0] state_q, state_next, seed_safe;
  logic [WIDTH+1:0] ext;
  logic             seed_zero, flag_q;

  ca_boundary #(.WIDTH(WIDTH), .CYCLIC(CYCLIC)) u_boundary (
    .state_i (state_q),
    .ext_o   (ext)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    localparam ca_rule_e CELL_RULE = RULE150_MASK[i] ? RULE_150 : RULE_90;
    ca_cell #(.RULE(CELL_RULE)) u_cell (
      .left_i  (ext[i]),
      .self_i  (ext[i+1]),
      .right_i (ext[i+2]),
      .next_o  (state_next[i])
    );
  end

  ca_seed_guard #(.WIDTH(WIDTH)) u_guard (
    .seed_i (seed_i),
    .seed_o (seed_safe),
    .zero_o (seed_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RESET_STATE;
      flag_q  <= 1'b0;
    end else begin
      flag_q <= load_i & seed_zero;
      if (load_i)        state_q <= seed_safe;
      else if (enable_i) state_q <= state_next;
    end
  end

  assign state_o     = state_q;
  assign seed_zero_o = flag_q;

  // R2
  load_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i != '0) |=> state_o == $past(seed_i));
  // R3
  zero_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i == '0) |=> (state_o == ONE_HOT0 && seed_zero_o));
  // R3
  flag_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_zero_o |-> state_o == ONE_HOT0);
  // R3
  flag_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> !seed_zero_o);
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !enable_i) |=> $stable(state_o));
endmodule

// File: tb/hybrid_ca_gen_bench.sv
`timescale 1ns/1ps
module hybrid_ca_gen_bench;
  localparam int unsigned W = 6;
  localparam logic [W-1:0] MASK = 6'b000001;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0;
  logic enable_i = 1'b0;
  logic [W-1:0] seed_i = '0;
  logic [W-1:0] st_n, st_c;
  logic fl_n, fl_c;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] exp_n, exp_c;
  logic exp_f;

  always #2.5 clk_i = ~clk_i;

  hybrid_ca_gen #(.WIDTH(W), .RULE150_MASK(MASK)) u_hybrid_ca_gen (
    .clk_i, .rst_ni, .load_i, .seed_i, .enable_i,
    .state_o(st_n), .seed_zero_o(fl_n)
  );

  hybrid_ca_gen #(.WIDTH(W), .RULE150_MASK(MASK), .CYCLIC(1'b1)) u_cyc (
    .clk_i, .rst_ni, .load_i, .seed_i, .enable_i,
    .state_o(st_c), .seed_zero_o(fl_c)
  );

  // Reference model built directly from the rules
  function automatic logic [W-1:0] step(logic [W-1:0] s, logic [W-1:0] m, bit cyc);
    logic [W-1:0] n;
    for (int i = 0; i < W; i++) begin
      logic l, r;
      l = (i == 0)     ? (cyc ? s[W-1] : 1'b0) : s[i-1];
      r = (i == W - 1) ? (cyc ? s[0]   : 1'b0) : s[i+1];
      n[i] = l ^ r ^ (m[i] & s[i]);
    end
    return n;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(logic l, logic [W-1:0] sd, logic en, string tag);
    load_i = l; seed_i = sd; enable_i = en;
    @(posedge clk_i); #1;
    if (l) begin
      exp_n = (sd == '0) ? W'(1) : sd;
      exp_c = exp_n;
      exp_f = (sd == '0);
    end else begin
      if (en) begin
        exp_n = step(exp_n, MASK, 1'b0);
        exp_c = step(exp_c, MASK, 1'b1);
      end
      exp_f = 1'b0;
    end
    check({tag, " null"}, st_n, exp_n);
    check("R8 cyclic", st_c, exp_c);
    check("R3 flag", W'(fl_n), W'(exp_f));
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] start;
    bit seen [64];
    int period;
    bit repeated;
    void'($urandom(32'hCA90_0150));
    #12;
    check("R1 reset state", st_n, W'(1));
    check("R1 reset flag", W'(fl_n), '0);
    @(posedge clk_i); #1; rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1 after reset", st_n, W'(1));
    exp_n = W'(1); exp_c = W'(1); exp_f = 1'b0;

    // R5 R6 R7: single-bit seeds expose each cell's neighbours
    for (int b = 0; b < W; b++) begin
      apply(1'b1, W'(1) << b, 1'b0, "R2 load");
      apply(1'b0, '0, 1'b1, "R5 R6 R7 step");
    end
    // R3 zero seed, with and without enable
    apply(1'b1, '0, 1'b1, "R3 zero seed");
    apply(1'b0, '0, 1'b0, "R4 hold after zero");
    apply(1'b1, '0, 1'b0, "R3 zero seed");
    // R2 load has priority over enable
    apply(1'b1, 6'b101101, 1'b1, "R2 load priority");

    // Constrained random mix
    for (int k = 0; k < 400; k++) begin
      logic l, e;
      logic [W-1:0] sd;
      l = ($urandom_range(0, 9) == 0);
      e = ($urandom_range(0, 3) != 0);
      sd = ($urandom_range(0, 7) == 0) ? '0 : W'($urandom);
      apply(l, sd, e, l ? "R2 R3 load" : (e ? "R5 R6 step" : "R4 hold"));
    end

    // R9 period from a random non-zero seed
    start = W'($urandom_range(1, 63));
    apply(1'b1, start, 1'b0, "R9 seed");
    for (int i = 0; i < 64; i++) seen[i] = 1'b0;
    period = 0; repeated = 1'b0;
    seen[st_n] = 1'b1;
    for (int i = 0; i < 70; i++) begin
      apply(1'b0, '0, 1'b1, "R9 step");
      period++;
      if (st_n == start) break;
      if (seen[st_n]) repeated = 1'b1;
      seen[st_n] = 1'b1;
    end
    check("R9 period", W'(period), W'(63));
    check("R9 no early repeat", W'(repeated), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule